// File: doc/BRIEF.md
# MMU Control Register File

This block holds the memory-management and exception bookkeeping words of a processor core: a translation control word, the high and low halves of a page-table entry, a small assistance field, the translation table base, the faulting address, and three 11-bit event codes (trap, exception, interrupt). It sits on a simple single-cycle register bus. Every request is answered one clock later with read data or an error flag. The translation buffer and the exception sequencing live elsewhere. This block only keeps the values and emits two one-clock control strobes.

Two writes have side effects. Writing the control word with its invalidate bit set produces an invalidate strobe, and that bit is never stored. Writing the page-table-entry high word with a new address-space identifier in its low byte produces a flush strobe. Three read-only identification words return fixed parameter values. A 16-bit counter word increments itself after each read.

Top module: `mmu_ctl_regfile`

## Requirements
- R1: The control word at offset 0x00 stores all 32 written bits except bit 2 (the invalidate bit), which always reads back as 0.
- R2: An accepted write to offset 0x00 with bit 2 set raises `tlb_inval_pulse` for exactly one clock, in the same cycle as the response. No other access raises it.
- R3: Bits [7:0] of the page-table-entry high word at offset 0x04 are the address-space identifier. An accepted write that changes them raises `tlb_flush_pulse` for exactly one clock, in the response cycle. A write that leaves them equal does not raise it.
- R4: The assistance word at offset 0x34 keeps only write bits [3:0] and reads back zero-extended.
- R5: The trap code (0x14), exception event (0x18) and interrupt event (0x1C) words each keep only write bits [10:0] and read back zero-extended.
- R6: The page-table-entry high (0x04), page-table-entry low (0x08), table base (0x0C) and fault address (0x10) words keep all 32 bits.
- R7: Offsets 0x30, 0x40 and 0x44 return the processor version, cache version and revision constants on read. A write to them is rejected as in R10.
- R8: The counter at offset 0x48 is accessed with half-word size only. A read returns the current value zero-extended, and the counter then holds that value plus 1 (modulo 2^16). A write loads it.
- R9: `req_size` encodes 0 = byte, 1 = half-word, 2 = word, 3 = reserved. All offsets except 0x48 need word size. Each request cycle is followed by exactly one cycle of `rsp_valid`, carrying the read data (0 for writes).
- R10: A request of the wrong size, to an unmapped offset, or writing a read-only word sets `rsp_err` with `rsp_rdata` = 0. It changes no register and raises no strobe.
- R11: After reset every writable word and the counter read 0, and `rsp_valid`, `rsp_err` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_size | input | 2 | Access size code |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | DATA_W | Read data |
| tlb_inval_pulse | output | 1 | One-clock translation buffer invalidate strobe |
| tlb_flush_pulse | output | 1 | One-clock flush strobe on identifier change |

## Verification
The assertions assume that `req_addr`, `req_size` and `req_write` hold defined values whenever `req_valid` is high, and that each request lasts one cycle. Back-to-back requests are allowed. The bench changes inputs only on the falling clock edge and draws offsets and sizes from a set that contains only defined codes. That set covers mapped, unmapped and read-only offsets and every size code, so rejected requests appear alongside accepted ones. Identifier values for the page-table-entry high word come from a four-entry pool, so changed and unchanged identifiers both occur often.

// File: rtl/mmureg_pkg.sv
package mmureg_pkg;

  typedef enum logic [3:0] {
    SEL_CTL, SEL_PTHI, SEL_PTLO, SEL_TBASE, SEL_FADDR,
    SEL_TRAP, SEL_EXC, SEL_INT, SEL_ASSIST,
    SEL_PVER, SEL_CVER, SEL_PREV, SEL_CNT, SEL_NONE
  } sel_e;

  typedef enum logic [1:0] { SZ_BYTE, SZ_HALF, SZ_WORD, SZ_RSVD } size_e;

  localparam int OFF_CTL    = 'h00;
  localparam int OFF_PTHI   = 'h04;
  localparam int OFF_PTLO   = 'h08;
  localparam int OFF_TBASE  = 'h0C;
  localparam int OFF_FADDR  = 'h10;
  localparam int OFF_TRAP   = 'h14;
  localparam int OFF_EXC    = 'h18;
  localparam int OFF_INT    = 'h1C;
  localparam int OFF_PVER   = 'h30;
  localparam int OFF_ASSIST = 'h34;
  localparam int OFF_CVER   = 'h40;
  localparam int OFF_PREV   = 'h44;
  localparam int OFF_CNT    = 'h48;

  localparam int N_EVT = 3;

endpackage

// File: rtl/mmureg_decode.sv
module mmureg_decode
  import mmureg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  output sel_e              sel,
  output logic              ok
);

  logic size_ok;
  logic ro;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFF_CTL))    sel = SEL_CTL;
    else if (addr == ADDR_W'(OFF_PTHI))   sel = SEL_PTHI;
    else if (addr == ADDR_W'(OFF_PTLO))   sel = SEL_PTLO;
    else if (addr == ADDR_W'(OFF_TBASE))  sel = SEL_TBASE;
    else if (addr == ADDR_W'(OFF_FADDR))  sel = SEL_FADDR;
    else if (addr == ADDR_W'(OFF_TRAP))   sel = SEL_TRAP;
    else if (addr == ADDR_W'(OFF_EXC))    sel = SEL_EXC;
    else if (addr == ADDR_W'(OFF_INT))    sel = SEL_INT;
    else if (addr == ADDR_W'(OFF_ASSIST)) sel = SEL_ASSIST;
    else if (addr == ADDR_W'(OFF_PVER))   sel = SEL_PVER;
    else if (addr == ADDR_W'(OFF_CVER))   sel = SEL_CVER;
    else if (addr == ADDR_W'(OFF_PREV))   sel = SEL_PREV;
    else if (addr == ADDR_W'(OFF_CNT))    sel = SEL_CNT;
  end

  always_comb begin
    if (sel == SEL_CNT) size_ok = (size == SZ_HALF);
    else                size_ok = (size == SZ_WORD);
    ro = (sel == SEL_PVER) || (sel == SEL_CVER) || (sel == SEL_PREV);
    ok = (sel != SEL_NONE) && size_ok && !(write && ro);
  end

endmodule

// File: rtl/mmureg_store.sv
module mmureg_store
  import mmureg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ASID_W   = 8,
  parameter int INV_BIT  = 2,
  parameter int EVT_W    = 11,
  parameter int ASSIST_W = 4,
  parameter int CNT_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         acc,
  input  logic                         wr,
  input  sel_e                         sel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            ctl_q,
  output logic [DATA_W-1:0]            pthi_q,
  output logic [DATA_W-1:0]            ptlo_q,
  output logic [DATA_W-1:0]            tbase_q,
  output logic [DATA_W-1:0]            faddr_q,
  output logic [N_EVT-1:0][EVT_W-1:0]  evt_q,
  output logic [ASSIST_W-1:0]          assist_q,
  output logic [CNT_W-1:0]             cnt_q,
  output logic                         inval_o,
  output logic                         flush_o
);

  localparam logic [DATA_W-1:0] INV_MASK = ~(DATA_W'(1) << INV_BIT);

  logic wr_en;
  logic rd_cnt;
  assign wr_en  = acc && wr;
  assign rd_cnt = acc && !wr && (sel == SEL_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      pthi_q   <= '0;
      ptlo_q   <= '0;
      tbase_q  <= '0;
      faddr_q  <= '0;
      assist_q <= '0;
      inval_o  <= 1'b0;
      flush_o  <= 1'b0;
    end else begin
      inval_o <= wr_en && (sel == SEL_CTL) && wdata[INV_BIT];
      flush_o <= wr_en && (sel == SEL_PTHI) &&
                 (wdata[ASID_W-1:0] != pthi_q[ASID_W-1:0]);
      if (wr_en) begin
        case (sel)
          SEL_CTL:    ctl_q    <= wdata & INV_MASK;
          SEL_PTHI:   pthi_q   <= wdata;
          SEL_PTLO:   ptlo_q   <= wdata;
          SEL_TBASE:  tbase_q  <= wdata;
          SEL_FADDR:  faddr_q  <= wdata;
          SEL_ASSIST: assist_q <= wdata[ASSIST_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              cnt_q <= '0;
    else if (wr_en && (sel == SEL_CNT))   cnt_q <= wdata[CNT_W-1:0];
    else if (rd_cnt)                      cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    localparam sel_e EV_SEL = sel_e'(int'(SEL_TRAP) + g);
    always_ff @(posedge clk) begin
      if (rst)                             evt_q[g] <= '0;
      else if (wr_en && (sel == EV_SEL))   evt_q[g] <= wdata[EVT_W-1:0];
    end
  end

  AST_FLUSH_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> (pthi_q[ASID_W-1:0] != $past(pthi_q[ASID_W-1:0]))); // R3

  AST_CNT_POST_INC: assert property (@(posedge clk) disable iff (rst)
    rd_cnt |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8

endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile
  import mmureg_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          ASID_W   = 8,
  parameter int          INV_BIT  = 2,
  parameter int          EVT_W    = 11,
  parameter int          ASSIST_W = 4,
  parameter int          CNT_W    = 16,
  parameter logic [31:0] PVER_VAL = 32'h0406_0110,
  parameter logic [31:0] CVER_VAL = 32'h2011_0208,
  parameter logic [31:0] PREV_VAL = 32'h0000_0113
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tlb_inval_pulse,
  output logic              tlb_flush_pulse
);

  sel_e                        sel;
  logic                        dec_ok;
  logic                        acc;
  logic [DATA_W-1:0]           ctl_q, pthi_q, ptlo_q, tbase_q, faddr_q;
  logic [N_EVT-1:0][EVT_W-1:0] evt_q;
  logic [ASSIST_W-1:0]         assist_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [DATA_W-1:0]           rd_mux;

  assign acc = req_valid && dec_ok;

  mmureg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (req_addr),
    .size  (req_size),
    .write (req_write),
    .sel   (sel),
    .ok    (dec_ok)
  );

  mmureg_store #(
    .DATA_W(DATA_W), .ASID_W(ASID_W), .INV_BIT(INV_BIT),
    .EVT_W(EVT_W), .ASSIST_W(ASSIST_W), .CNT_W(CNT_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .wr       (req_write),
    .sel      (sel),
    .wdata    (req_wdata),
    .ctl_q    (ctl_q),
    .pthi_q   (pthi_q),
    .ptlo_q   (ptlo_q),
    .tbase_q  (tbase_q),
    .faddr_q  (faddr_q),
    .evt_q    (evt_q),
    .assist_q (assist_q),
    .cnt_q    (cnt_q),
    .inval_o  (tlb_inval_pulse),
    .flush_o  (tlb_flush_pulse)
  );

  always_comb begin
    case (sel)
      SEL_CTL:    rd_mux = ctl_q;
      SEL_PTHI:   rd_mux = pthi_q;
      SEL_PTLO:   rd_mux = ptlo_q;
      SEL_TBASE:  rd_mux = tbase_q;
      SEL_FADDR:  rd_mux = faddr_q;
      SEL_TRAP:   rd_mux = DATA_W'(evt_q[0]);
      SEL_EXC:    rd_mux = DATA_W'(evt_q[1]);
      SEL_INT:    rd_mux = DATA_W'(evt_q[2]);
      SEL_ASSIST: rd_mux = DATA_W'(assist_q);
      SEL_PVER:   rd_mux = DATA_W'(PVER_VAL);
      SEL_CVER:   rd_mux = DATA_W'(CVER_VAL);
      SEL_PREV:   rd_mux = DATA_W'(PREV_VAL);
      SEL_CNT:    rd_mux = DATA_W'(cnt_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !dec_ok;
      rsp_rdata <= (acc && !req_write) ? rd_mux : '0;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R9

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R9

  AST_CTL_READ_NO_INV: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write && sel == SEL_CTL) |=> !rsp_rdata[INV_BIT]); // R1

  AST_INV_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && sel == SEL_CTL && req_wdata[INV_BIT]) |=> tlb_inval_pulse); // R2

  AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dec_ok) |=> ($stable(ctl_q) && $stable(pthi_q) && $stable(ptlo_q) &&
      $stable(tbase_q) && $stable(faddr_q) && $stable(evt_q) && $stable(assist_q) &&
      $stable(cnt_q) && !tlb_inval_pulse && !tlb_flush_pulse && rsp_err)); // R10

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0)); // R10

endmodule

// File: tb/mmu_ctl_regfile_tb.sv
module mmu_ctl_regfile_tb;

  localparam logic [31:0] PVER = 32'h0406_0110;
  localparam logic [31:0] CVER = 32'h2011_0208;
  localparam logic [31:0] PREV = 32'h0000_0113;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, tlb_inval_pulse, tlb_flush_pulse;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  mmu_ctl_regfile u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .tlb_inval_pulse(tlb_inval_pulse), .tlb_flush_pulse(tlb_flush_pulse)
  );

  // bench model
  logic [31:0] m_ctl, m_pthi, m_ptlo, m_tbase, m_faddr;
  logic [10:0] m_trap, m_exc, m_int;
  logic [3:0]  m_assist;
  logic [15:0] m_cnt;

  function automatic bit mapped_ok(bit wr, logic [7:0] a, logic [1:0] sz);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h34: return sz == 2'd2;
      8'h30, 8'h40, 8'h44: return (sz == 2'd2) && !wr;
      8'h48: return sz == 2'd1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return m_ctl;
      8'h04: return m_pthi;
      8'h08: return m_ptlo;
      8'h0C: return m_tbase;
      8'h10: return m_faddr;
      8'h14: return {21'b0, m_trap};
      8'h18: return {21'b0, m_exc};
      8'h1C: return {21'b0, m_int};
      8'h34: return {28'b0, m_assist};
      8'h30: return PVER;
      8'h40: return CVER;
      8'h44: return PREV;
      8'h48: return {16'b0, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(bit wr, logic [7:0] a, logic [1:0] sz, logic [31:0] d, string req);
    bit ok;
    logic [31:0] e_rd;
    bit e_inv, e_fl;
    ok    = mapped_ok(wr, a, sz);
    e_rd  = (ok && !wr) ? model_read(a) : 32'h0;
    e_inv = ok && wr && (a == 8'h00) && d[2];
    e_fl  = ok && wr && (a == 8'h04) && (d[7:0] != m_pthi[7:0]);
    if (ok) begin
      if (wr) begin
        case (a)
          8'h00: m_ctl = d & ~32'h4;
          8'h04: m_pthi = d;
          8'h08: m_ptlo = d;
          8'h0C: m_tbase = d;
          8'h10: m_faddr = d;
          8'h14: m_trap = d[10:0];
          8'h18: m_exc = d[10:0];
          8'h1C: m_int = d[10:0];
          8'h34: m_assist = d[3:0];
          8'h48: m_cnt = d[15:0];
          default: ;
        endcase
      end else if (a == 8'h48) begin
        m_cnt = m_cnt + 16'd1;
      end
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
    check(req, "rsp_err",   32'(rsp_err),   32'(!ok));
    check(req, "rsp_rdata", rsp_rdata, e_rd);
    check(req, "inval",     32'(tlb_inval_pulse), 32'(e_inv));
    check(req, "flush",     32'(tlb_flush_pulse), 32'(e_fl));
  endtask

  task automatic idle(string req);
    @(negedge clk);
    check(req, "idle rsp_valid", 32'(rsp_valid), 32'd0);
    check(req, "idle inval", 32'(tlb_inval_pulse), 32'd0);
    check(req, "idle flush", 32'(tlb_flush_pulse), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pool [16];
    logic [7:0] asids [4];
    pool = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
             8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h02, 8'h20};
    asids = '{8'h00, 8'h11, 8'hA5, 8'hFF};
    {m_ctl, m_pthi, m_ptlo, m_tbase, m_faddr} = '0;
    {m_trap, m_exc, m_int, m_assist, m_cnt} = '0;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11", "rsp_err", 32'(rsp_err), 32'd0);
    check("R11", "inval", 32'(tlb_inval_pulse), 32'd0);
    check("R11", "flush", 32'(tlb_flush_pulse), 32'd0);
    foreach (pool[i]) if (pool[i] != 8'h48 && pool[i] < 8'h4C && pool[i] != 8'h02 && pool[i] != 8'h20)
      op(1'b0, pool[i], 2'd2, 32'h0, "R11");
    op(1'b0, 8'h48, 2'd1, 32'h0, "R11");

    // R1 / R2 invalidate bit
    op(1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF, "R2");
    idle("R2");
    op(1'b0, 8'h00, 2'd2, 32'h0, "R1");
    op(1'b1, 8'h00, 2'd2, 32'h1234_5673, "R2");
    op(1'b1, 8'h00, 2'd2, 32'h0000_0004, "R2");
    op(1'b1, 8'h00, 2'd2, 32'h0000_0003, "R1");
    op(1'b0, 8'h00, 2'd2, 32'h0, "R1");

    // R3 identifier flush
    op(1'b1, 8'h04, 2'd2, 32'hDEAD_BE42, "R3");
    idle("R3");
    op(1'b1, 8'h04, 2'd2, 32'h0000_0042, "R3");
    op(1'b1, 8'h04, 2'd2, 32'h0000_0043, "R3");
    op(1'b0, 8'h04, 2'd2, 32'h0, "R6");

    // R4 / R5 / R6 masks
    op(1'b1, 8'h34, 2'd2, 32'hFFFF_FFFF, "R4");
    op(1'b0, 8'h34, 2'd2, 32'h0, "R4");
    op(1'b1, 8'h14, 2'd2, 32'hFFFF_FFFF, "R5");
    op(1'b1, 8'h18, 2'd2, 32'hAAAA_A955, "R5");
    op(1'b1, 8'h1C, 2'd2, 32'h5555_5AAA, "R5");
    op(1'b0, 8'h14, 2'd2, 32'h0, "R5");
    op(1'b0, 8'h18, 2'd2, 32'h0, "R5");
    op(1'b0, 8'h1C, 2'd2, 32'h0, "R5");
    op(1'b1, 8'h08, 2'd2, 32'hCAFE_F00D, "R6");
    op(1'b1, 8'h0C, 2'd2, 32'h8000_0001, "R6");
    op(1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF, "R6");
    op(1'b0, 8'h08, 2'd2, 32'h0, "R6");
    op(1'b0, 8'h0C, 2'd2, 32'h0, "R6");
    op(1'b0, 8'h10, 2'd2, 32'h0, "R6");

    // R7 constants, write rejected
    op(1'b0, 8'h30, 2'd2, 32'h0, "R7");
    op(1'b1, 8'h40, 2'd2, 32'h1, "R7");
    op(1'b0, 8'h40, 2'd2, 32'h0, "R7");
    op(1'b0, 8'h44, 2'd2, 32'h0, "R7");

    // R8 counter, wrap
    op(1'b1, 8'h48, 2'd1, 32'h0000_FFFE, "R8");
    op(1'b0, 8'h48, 2'd1, 32'h0, "R8");
    op(1'b0, 8'h48, 2'd1, 32'h0, "R8");
    op(1'b0, 8'h48, 2'd1, 32'h0, "R8");

    // R10 rejections
    op(1'b1, 8'h00, 2'd1, 32'h4, "R10");
    op(1'b1, 8'h04, 2'd3, 32'hFF, "R10");
    op(1'b0, 8'h48, 2'd2, 32'h0, "R10");
    op(1'b1, 8'h4C, 2'd2, 32'h4, "R10");
    op(1'b0, 8'h02, 2'd2, 32'h0, "R10");
    op(1'b0, 8'h00, 2'd2, 32'h0, "R10");
    op(1'b0, 8'h48, 2'd1, 32'h0, "R10");

    // R9 random mix, back-to-back
    for (int n = 0; n < 600; n++) begin
      bit          wr;
      logic [7:0]  a;
      logic [1:0]  sz;
      logic [31:0] d;
      wr = $urandom_range(0, 1);
      a  = pool[$urandom_range(0, 15)];
      sz = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) :
           ((a == 8'h48) ? 2'd1 : 2'd2);
      d  = $urandom();
      if (a == 8'h04) d[7:0] = asids[$urandom_range(0, 3)];
      if (a == 8'h00 && $urandom_range(0, 1) == 0) d[2] = 1'b0;
      op(wr, a, sz, d, "R9");
      if ($urandom_range(0, 4) == 0) idle("R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule